// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block fetches transmit work for an Ethernet MAC. It follows a chain of descriptors in host memory. Each descriptor is three 32-bit words: a link to the next descriptor at byte offset 0, a command/status word at offset 4 and a buffer pointer at offset 8. For each descriptor the walker reads the three words and checks the host-ownership flag. It then requests the buffer data into the transmit FIFO in bursts of bounded size. When the buffer is used up, it writes the updated command/status word back and moves on along the link.

All memory traffic goes through one request/done handshake. A request carries an operation code, a byte address and a byte length, and it is held until the memory side pulses done. Descriptor and link words come back on dedicated read buses in the same cycle as done. Free FIFO space is reported by a single level input. The MAC reports the end of a packet with a done level and two error flags.

The walker also keeps a "current descriptor done" flag. It is set when the chain ends on a null link. It makes the next start re-read only the link word of the descriptor it stopped on, so the engine never transmits that descriptor twice.

Top module: `txdesc_walker`

## Requirements
- R1: After reset, `mem_req` is low. The walker issues no request until a start command is seen. The done flag is clear.
- R2: A start with the done flag clear issues a descriptor read: operation code 0, address = current descriptor, length 12. The returned words are link (`rd_link`), command/status (`rd_cmdsts`) and buffer pointer (`rd_bufptr`).
- R3: A start with the done flag set issues a link read: operation code 1, address = current descriptor, length 4. The walker then follows the returned link.
- R4: If a descriptor read returns ownership bit 31 clear, the walker goes idle and issues no further request. A later start reads the same descriptor again.
- R5: Fragment reads (operation code 2) start only while `fifo_avail` is high. Their total length equals the byte count in command/status bits 11:0. They cover consecutive addresses from the buffer pointer.
- R6: Each fragment read is no longer than the burst limit given by `burst_code`. Code 0 means 512 bytes. Code n (1 to 7) means 2^(n+1) bytes. Only the last burst of a descriptor may be shorter.
- R7: When continuation bit 30 is set, the status write follows the last fragment without waiting for `pkt_done`, and it reports bits 26 and 25 as 0.
- R8: When bit 30 is clear, the status write waits for `pkt_done` high. It copies `pkt_abort` into bit 26 and `pkt_underrun` into bit 25.
- R9: The status write (operation code 3) goes to descriptor address + 4 with length 4. Its data is the fetched command/status word with bit 31 cleared, bits 26 and 25 replaced, and all other bits unchanged.
- R10: After the status write, a non-zero link starts a descriptor read at that link. A zero link sends the walker idle with the done flag set.
- R11: A start command that arrives while the walker is busy is kept. It is serviced once the walker returns to idle.
- R12: While a request is pending, its operation code, address and length stay stable until `mem_done`.
- R13: A descriptor with byte count 0 issues no fragment read and goes straight to its status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txe_cmd | input | 1 | Start (transmit enable) command pulse |
| head_we | input | 1 | Load the current descriptor address; honoured only when idle, and it clears the done flag |
| head_addr | input | ADDR_W | Descriptor address to load |
| burst_code | input | 3 | Maximum burst size code |
| fifo_avail | input | 1 | Transmit FIFO has room for a burst |
| pkt_done | input | 1 | MAC has finished the packet |
| pkt_abort | input | 1 | Packet was aborted (valid with pkt_done) |
| pkt_underrun | input | 1 | Packet hit a FIFO underrun (valid with pkt_done) |
| mem_req | output | 1 | Memory request pending |
| mem_op | output | 2 | 0 descriptor read, 1 link read, 2 fragment read, 3 status write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_len | output | 13 | Request byte length |
| mem_wdata | output | 32 | Status word for a write request |
| mem_done | input | 1 | One-cycle completion of the pending request |
| rd_link | input | 32 | Link word returned by descriptor and link reads |
| rd_cmdsts | input | 32 | Command/status word returned by a descriptor read |
| rd_bufptr | input | 32 | Buffer pointer returned by a descriptor read |

## Verification
The bench builds real chains in a small memory model and predicts every request in order. It targets the corners where a wrong design behaves visibly differently:
- A 600-byte buffer under the 512-byte code must split into 512 and 88. A wrong burst decode shows up as a different split.
- A zero-length descriptor must not issue a zero-byte or phantom fragment.
- A start that lands mid-chain must produce a link re-read once the chain ends. A design that drops the command stays silent instead.
- With FIFO space withheld, or with the packet-done input held low, no request may appear. A design that ignores either input would issue it early.
- A descriptor the host has not handed over must end the run after one read. It must be read again on the next start.

// File: rtl/txdw_pkg.sv
`timescale 1ns/1ps
package txdw_pkg;
  localparam int WORD_W     = 32;
  localparam int CNT_W      = 12;
  localparam int LEN_W      = CNT_W + 1;
  localparam int OWN_BIT    = 31;
  localparam int MORE_BIT   = 30;
  localparam int ABORT_BIT  = 26;
  localparam int UNDER_BIT  = 25;
  localparam int DESC_BYTES = 12;
  localparam int LINK_BYTES = 4;
  localparam int CMD_OFS    = 4;
  localparam int MAX_BURST  = 512;

  typedef enum logic [1:0] {
    OP_DESC_RD = 2'd0,
    OP_LINK_RD = 2'd1,
    OP_FRAG_RD = 2'd2,
    OP_STAT_WR = 2'd3
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REFRESH,
    ST_DESC_RD,
    ST_FIFO_WAIT,
    ST_FRAG_RD,
    ST_STAT_WR,
    ST_ADVANCE
  } walk_state_e;
endpackage

// File: rtl/txdw_burst_calc.sv
`timescale 1ns/1ps
module txdw_burst_calc
  import txdw_pkg::*;
(
  input  logic [2:0]       code,
  input  logic [CNT_W-1:0] remaining,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] cap;
  logic [LEN_W-1:0] rem_ext;

  assign rem_ext = {1'b0, remaining};

  always_comb begin
    if (code == 3'd0) cap = LEN_W'(MAX_BURST);
    else              cap = LEN_W'(1) << ({1'b0, code} + 4'd1);
    len = (rem_ext < cap) ? rem_ext : cap;
  end
endmodule

// File: rtl/txdw_status_fmt.sv
`timescale 1ns/1ps
module txdw_status_fmt
  import txdw_pkg::*;
(
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              last_frag,
  input  logic              abort_in,
  input  logic              under_in,
  output logic [WORD_W-1:0] stat_word
);
  always_comb begin
    stat_word            = cmd_word;
    stat_word[OWN_BIT]   = 1'b0;
    stat_word[ABORT_BIT] = last_frag & abort_in;
    stat_word[UNDER_BIT] = last_frag & under_in;
  end
endmodule

// File: rtl/txdw_cmd_latch.sv
`timescale 1ns/1ps
module txdw_cmd_latch (
  input  logic clk,
  input  logic rst,
  input  logic cmd_in,
  input  logic take,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= cmd_in | (pending & ~take);
  end
endmodule

// File: rtl/txdesc_walker.sv
`timescale 1ns/1ps
module txdesc_walker
  import txdw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txe_cmd,
  input  logic              head_we,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [2:0]        burst_code,
  input  logic              fifo_avail,
  input  logic              pkt_done,
  input  logic              pkt_abort,
  input  logic              pkt_underrun,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_done,
  input  logic [WORD_W-1:0] rd_link,
  input  logic [WORD_W-1:0] rd_cmdsts,
  input  logic [WORD_W-1:0] rd_bufptr
);
  walk_state_e       state_q;
  mem_op_e           op_q;
  logic [ADDR_W-1:0] cur_q, link_q, frag_q;
  logic [WORD_W-1:0] cmd_q;
  logic [CNT_W-1:0]  rem_q;
  logic              done_flag_q;
  logic              pend, start;
  logic [LEN_W-1:0]  burst_len;
  logic [WORD_W-1:0] stat_word;
  logic              more_c;

  assign more_c = cmd_q[MORE_BIT];
  assign start  = (state_q == ST_IDLE) && pend && !head_we;
  assign mem_op = op_q;

  txdw_cmd_latch u_latch (
    .clk(clk), .rst(rst), .cmd_in(txe_cmd), .take(start), .pending(pend)
  );

  txdw_burst_calc u_burst (
    .code(burst_code), .remaining(rem_q), .len(burst_len)
  );

  txdw_status_fmt u_fmt (
    .cmd_word(cmd_q), .last_frag(!more_c), .abort_in(pkt_abort),
    .under_in(pkt_underrun), .stat_word(stat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_DESC_RD;
      cur_q       <= '0;
      link_q      <= '0;
      frag_q      <= '0;
      cmd_q       <= '0;
      rem_q       <= '0;
      done_flag_q <= 1'b0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      mem_len     <= '0;
      mem_wdata   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (head_we) begin
            cur_q       <= head_addr;
            done_flag_q <= 1'b0;
          end else if (start) begin
            mem_req  <= 1'b1;
            mem_addr <= cur_q;
            if (done_flag_q) begin
              op_q    <= OP_LINK_RD;
              mem_len <= LEN_W'(LINK_BYTES);
              state_q <= ST_REFRESH;
            end else begin
              op_q    <= OP_DESC_RD;
              mem_len <= LEN_W'(DESC_BYTES);
              state_q <= ST_DESC_RD;
            end
          end
        end
        ST_REFRESH: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            link_q  <= ADDR_W'(rd_link);
            state_q <= ST_ADVANCE;
          end
        end
        ST_DESC_RD: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            link_q  <= ADDR_W'(rd_link);
            cmd_q   <= rd_cmdsts;
            frag_q  <= ADDR_W'(rd_bufptr);
            rem_q   <= rd_cmdsts[CNT_W-1:0];
            state_q <= rd_cmdsts[OWN_BIT] ? ST_FIFO_WAIT : ST_IDLE;
          end
        end
        ST_FIFO_WAIT: begin
          if (rem_q != '0) begin
            if (fifo_avail) begin
              mem_req  <= 1'b1;
              op_q     <= OP_FRAG_RD;
              mem_addr <= frag_q;
              mem_len  <= burst_len;
              state_q  <= ST_FRAG_RD;
            end
          end else if (more_c || pkt_done) begin
            mem_req   <= 1'b1;
            op_q      <= OP_STAT_WR;
            mem_addr  <= cur_q + ADDR_W'(CMD_OFS);
            mem_len   <= LEN_W'(LINK_BYTES);
            mem_wdata <= stat_word;
            state_q   <= ST_STAT_WR;
          end
        end
        ST_FRAG_RD: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            frag_q  <= frag_q + ADDR_W'(mem_len);
            rem_q   <= rem_q - mem_len[CNT_W-1:0];
            state_q <= ST_FIFO_WAIT;
          end
        end
        ST_STAT_WR: begin
          if (mem_done) begin
            mem_req <= 1'b0;
            state_q <= ST_ADVANCE;
          end
        end
        ST_ADVANCE: begin
          if (link_q != '0) begin
            cur_q       <= link_q;
            done_flag_q <= 1'b0;
            mem_req     <= 1'b1;
            op_q        <= OP_DESC_RD;
            mem_addr    <= link_q;
            mem_len     <= LEN_W'(DESC_BYTES);
            state_q     <= ST_DESC_RD;
          end else begin
            done_flag_q <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_walker_chk.sv
`timescale 1ns/1ps
module txdesc_walker_chk
  import txdw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic [1:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LEN_W-1:0]  mem_len,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_done,
  input logic [2:0]        burst_code,
  input logic              fifo_avail,
  input logic              pkt_done
);
  logic [LEN_W-1:0] cap;
  always_comb begin
    if (burst_code == 3'd0) cap = LEN_W'(MAX_BURST);
    else                    cap = LEN_W'(1) << ({1'b0, burst_code} + 4'd1);
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_op)));

  assert_desc_len_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'(OP_DESC_RD)) |-> (mem_len == LEN_W'(DESC_BYTES)));

  assert_link_len_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'(OP_LINK_RD)) |-> (mem_len == LEN_W'(LINK_BYTES)));

  assert_frag_space_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_op == 2'(OP_FRAG_RD)) |-> $past(fifo_avail));

  assert_burst_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'(OP_FRAG_RD)) |-> (mem_len != '0 && mem_len <= cap));

  assert_last_waits_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_op == 2'(OP_STAT_WR) && !mem_wdata[MORE_BIT]) |-> $past(pkt_done));

  assert_own_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'(OP_STAT_WR)) |-> !mem_wdata[OWN_BIT]);
endmodule

bind txdesc_walker txdesc_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_op(mem_op),
  .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
  .mem_done(mem_done), .burst_code(burst_code), .fifo_avail(fifo_avail),
  .pkt_done(pkt_done)
);

// File: tb/txdesc_walker_test.sv
`timescale 1ns/1ps
module txdesc_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txe_cmd = 1'b0, head_we = 1'b0;
  logic [31:0] head_addr = '0;
  logic [2:0]  burst_code = 3'd4;
  logic        fifo_avail = 1'b1, pkt_done = 1'b1, pkt_abort = 1'b0, pkt_underrun = 1'b0;
  logic        mem_req;
  logic [1:0]  mem_op;
  logic [31:0] mem_addr, mem_wdata;
  logic [12:0] mem_len;
  logic        mem_done = 1'b0;
  logic [31:0] rd_link = '0, rd_cmdsts = '0, rd_bufptr = '0;

  int unsigned n_checks = 0, n_fail = 0;
  logic [31:0] mem [0:511];

  typedef struct {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [12:0] len;
    logic [31:0] wdata;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  txdesc_walker #(.ADDR_W(32)) uut (
    .clk(clk), .rst(rst), .txe_cmd(txe_cmd), .head_we(head_we), .head_addr(head_addr),
    .burst_code(burst_code), .fifo_avail(fifo_avail), .pkt_done(pkt_done),
    .pkt_abort(pkt_abort), .pkt_underrun(pkt_underrun), .mem_req(mem_req),
    .mem_op(mem_op), .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .rd_link(rd_link), .rd_cmdsts(rd_cmdsts), .rd_bufptr(rd_bufptr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expect_req(input logic [1:0] op, input logic [31:0] addr,
                            input logic [12:0] len, input logic [31:0] wd, input string tag);
    exp_t e;
    e.op = op; e.addr = addr; e.len = len; e.wdata = wd; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pulse_txe();
    @(negedge clk); txe_cmd = 1'b1;
    @(negedge clk); txe_cmd = 1'b0;
  endtask

  task automatic load_head(input logic [31:0] a);
    @(negedge clk); head_we = 1'b1; head_addr = a;
    @(negedge clk); head_we = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [31:0] lk, input logic [31:0] cs, input logic [31:0] bp);
    mem[a >> 2] = lk; mem[(a >> 2) + 1] = cs; mem[(a >> 2) + 2] = bp;
  endtask

  // Scoreboard monitor: compare each new request with the queue front
  bit req_seen = 1'b0;
  always @(negedge clk) begin
    if (rst || !mem_req) req_seen = 1'b0;
    else if (!req_seen) begin
      req_seen = 1'b1;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected request: actual op=%0d addr=%h len=%0d expected none",
                 mem_op, mem_addr, mem_len);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (mem_op != e.op || mem_addr != e.addr || mem_len != e.len ||
            (e.op == 2'd3 && mem_wdata != e.wdata)) begin
          n_fail++;
          $display("FAIL %s: actual op=%0d addr=%h len=%0d wdata=%h expected op=%0d addr=%h len=%0d wdata=%h",
                   e.tag, mem_op, mem_addr, mem_len, mem_wdata, e.op, e.addr, e.len, e.wdata);
        end
      end
    end
  end

  // Memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req) begin
        logic [1:0]  c_op;
        logic [31:0] c_addr;
        logic [12:0] c_len;
        int          idx;
        c_op = mem_op; c_addr = mem_addr; c_len = mem_len;
        repeat (3) @(negedge clk);
        chk(mem_op == c_op && mem_addr == c_addr && mem_len == c_len && mem_req,
            "R12 request held stable", mem_addr, c_addr);
        idx = int'(c_addr[10:2]);
        case (c_op)
          2'd0: begin rd_link = mem[idx]; rd_cmdsts = mem[idx + 1]; rd_bufptr = mem[idx + 2]; end
          2'd1: rd_link = mem[idx];
          2'd3: mem[idx] = mem_wdata;
          default: ;
        endcase
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'd0);

    // Two-descriptor packet, burst 32 bytes; second start while busy (R11)
    put_desc(32'h40, 32'h80, 32'hC000_0028, 32'h200);
    put_desc(32'h80, 32'h0,  32'h8000_0014, 32'h300);
    burst_code = 3'd4; pkt_abort = 1'b1; pkt_underrun = 1'b0;
    load_head(32'h40);
    expect_req(2'd0, 32'h40,  13'd12, '0, "R2 first descriptor read");
    expect_req(2'd2, 32'h200, 13'd32, '0, "R5 R6 first burst");
    expect_req(2'd2, 32'h220, 13'd8,  '0, "R5 R6 tail burst");
    expect_req(2'd3, 32'h44,  13'd4,  32'h4000_0028, "R7 R9 continued status");
    expect_req(2'd0, 32'h80,  13'd12, '0, "R10 follow link");
    expect_req(2'd2, 32'h300, 13'd20, '0, "R5 single burst");
    expect_req(2'd3, 32'h84,  13'd4,  32'h0400_0014, "R8 R9 last status abort");
    expect_req(2'd1, 32'h80,  13'd4,  '0, "R11 latched start refresh");
    pulse_txe();
    repeat (4) @(negedge clk);
    pulse_txe();
    drain();
    chk(mem[32'h44 >> 2] == 32'h4000_0028, "R9 status word in memory", mem[32'h44 >> 2], 32'h4000_0028);
    chk(mem[32'h84 >> 2] == 32'h0400_0014, "R8 status word in memory", mem[32'h84 >> 2], 32'h0400_0014);
    chk(mem_req == 1'b0, "R10 null link ends run", 32'(mem_req), 32'd0);

    // Refresh path then 600 bytes under the 512-byte code
    mem[32'h80 >> 2] = 32'hC0;
    put_desc(32'hC0, 32'h0, 32'h8000_0258, 32'h100);
    burst_code = 3'd0; pkt_abort = 1'b0; pkt_underrun = 1'b1;
    expect_req(2'd1, 32'h80,  13'd4,   '0, "R3 link re-read");
    expect_req(2'd0, 32'hC0,  13'd12,  '0, "R3 R10 follow new link");
    expect_req(2'd2, 32'h100, 13'd512, '0, "R6 code 0 full burst");
    expect_req(2'd2, 32'h300, 13'd88,  '0, "R6 code 0 remainder");
    expect_req(2'd3, 32'hC4,  13'd4,   32'h0200_0258, "R8 underrun status");
    pulse_txe();
    drain();

    // Ownership clear, then FIFO and packet-done gating
    load_head(32'hC0);
    expect_req(2'd0, 32'hC0, 13'd12, '0, "R4 read unowned descriptor");
    pulse_txe();
    drain();
    chk(mem_req == 1'b0, "R4 idle after unowned descriptor", 32'(mem_req), 32'd0);
    mem[32'hC4 >> 2] = 32'h8000_0008; mem[32'hC8 >> 2] = 32'h600;
    burst_code = 3'd4; fifo_avail = 1'b0; pkt_done = 1'b0;
    expect_req(2'd0, 32'hC0, 13'd12, '0, "R4 same descriptor read again");
    pulse_txe();
    drain();
    repeat (10) @(negedge clk);
    chk(mem_req == 1'b0, "R5 no fragment without FIFO space", 32'(mem_req), 32'd0);
    expect_req(2'd2, 32'h600, 13'd8, '0, "R5 fragment once space appears");
    fifo_avail = 1'b1;
    drain();
    repeat (10) @(negedge clk);
    chk(mem_req == 1'b0, "R8 status waits for packet done", 32'(mem_req), 32'd0);
    expect_req(2'd3, 32'hC4, 13'd4, 32'h0600_0008, "R8 both error flags");
    pkt_abort = 1'b1; pkt_underrun = 1'b1;
    @(negedge clk); pkt_done = 1'b1;
    drain();

    // Zero-length continued descriptor, then 4-byte bursts
    put_desc(32'h140, 32'h180, 32'hC000_0000, 32'h700);
    put_desc(32'h180, 32'h0,   32'h8000_000A, 32'h500);
    burst_code = 3'd1; pkt_abort = 1'b0; pkt_underrun = 1'b0;
    load_head(32'h140);
    expect_req(2'd0, 32'h140, 13'd12, '0, "R13 zero-length descriptor read");
    expect_req(2'd3, 32'h144, 13'd4,  32'h4000_0000, "R13 R7 direct status write");
    expect_req(2'd0, 32'h180, 13'd12, '0, "R10 next descriptor");
    expect_req(2'd2, 32'h500, 13'd4,  '0, "R6 code 1 burst");
    expect_req(2'd2, 32'h504, 13'd4,  '0, "R6 code 1 burst");
    expect_req(2'd2, 32'h508, 13'd2,  '0, "R6 code 1 tail");
    expect_req(2'd3, 32'h184, 13'd4,  32'h0000_000A, "R9 clean status");
    pulse_txe();
    drain();
    chk(mem[32'h184 >> 2] == 32'h0000_000A, "R9 owner returned to host", mem[32'h184 >> 2], 32'h0000_000A);

    finish_run();
  end
endmodule